// File: doc/BRIEF.md
# Register-Mapped Multiply/Divide Unit

An arithmetic peripheral in a 16-byte window of an 8-bit register bus. Software loads operand bytes, then writes the high byte of either the multiplier or the divisor. That write starts a 16-cycle shift-and-add multiply (16x16 to 32 bits) or a 32-cycle restoring divide (32/16 to a 32-bit quotient and a 16-bit remainder). The result bytes change only when the operation completes. A one-bit mode in the control byte selects unsigned or two's-complement arithmetic. Signed operations run on magnitudes, and the signs are applied when the result is written.

Writing the control byte clears every operand, result and remainder byte and cancels any operation in flight. A status byte shows 0x80 once after each completed operation. The read that returns 0x80 clears the flag.

Top module: `muldiv_regs`

## Requirements
- R1: After reset every byte of the window reads 0x00, including the control byte (offset 14) and the status byte (offset 15).
- R2: Offsets 0-3 hold the 32-bit dividend, little-endian, and offsets 0-1 also form the 16-bit multiplicand. Offsets 4-5 hold the multiplier and offsets 6-7 the divisor, both little-endian. All eight bytes read back as written. Writes to offsets 8-13 and 15 have no effect.
- R3: A write to offset 5 starts an unsigned multiply of {byte1,byte0} by {byte5,byte4}. Exactly 16 clocks after the write edge, the 32-bit product appears little-endian in offsets 8-11. The result bytes do not change before that edge.
- R4: When control bit 0 is 1, multiply operands are two's complement and the product is the signed 32-bit product (for example 0x8000 x 0x8000 = 0x40000000).
- R5: A write to offset 7 starts an unsigned divide of bytes 0-3 by {byte7,byte6}. Exactly 32 clocks after the write edge, the quotient appears in offsets 8-11 and the remainder in offsets 12-13.
- R6: In signed mode the divide truncates toward zero and the remainder takes the sign of the dividend. The quotient is the low 32 bits of the exact quotient, so 0x80000000 / -1 gives 0x80000000.
- R7: A divisor of zero gives quotient 0 and a remainder equal to the low 16 bits of the dividend, in either mode.
- R8: The status byte reads 0x00 while an operation runs. After completion it reads 0x80 once. That read clears it, and later reads return 0x00 until another operation completes.
- R9: A write to offset 14 stores the byte as control (reads back whole), zeroes offsets 0-13, clears the status flag and cancels a running operation, so no result is written later.
- R10: A start write during a running operation restarts it with the current operands, and the full latency counts from the new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the byte at addr |
| rd_en | input | 1 | Read strobe; a status read clears the flag at the clock edge |
| addr | input | 4 | Byte offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |

## Verification
The hardest situations to reach from the ports are the collisions in time. These are a restart or a control write arriving partway through an operation, and a status read landing on the completion edge. The bench polls the status byte every cycle of each operation, and a reference model counts down the latency cycle by cycle. Dedicated sequences re-write the multiplier high byte five cycles into a multiply and write the control byte three cycles into a divide. A random phase mixes both modes with the most negative operands, all-ones values and zero divisors.

// File: rtl/muldiv_regs.sv
module muldiv_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int MUL_N = 16;
  localparam int DIV_N = 32;
  localparam int CW = $clog2(DIV_N);
  localparam logic [3:0] A_MRH = 4'd5;
  localparam logic [3:0] A_DVH = 4'd7;
  localparam logic [3:0] A_CTL = 4'd14;
  localparam logic [3:0] A_STA = 4'd15;

  logic [31:0] dvd, res, wq;
  logic [15:0] mpy, dvs, rem, acc, wd, dlow;
  logic [7:0]  ctl;
  logic [CW-1:0] cnt;
  logic busy, is_div, done, neg_q, neg_r, dz;

  wire clr    = wr_en && addr == A_CTL;
  wire go_mul = wr_en && addr == A_MRH;
  wire go_div = wr_en && addr == A_DVH;
  wire go     = go_mul || go_div;
  wire sgn    = ctl[0];

  wire [15:0] mpy_n = {wdata, mpy[7:0]};
  wire [15:0] dvs_n = {wdata, dvs[7:0]};
  wire [15:0] mag_a = (sgn && dvd[15]) ? -dvd[15:0] : dvd[15:0];
  wire [15:0] mag_m = (sgn && mpy_n[15]) ? -mpy_n : mpy_n;
  wire [31:0] mag_d = (sgn && dvd[31]) ? -dvd : dvd;
  wire [15:0] mag_v = (sgn && dvs_n[15]) ? -dvs_n : dvs_n;

  wire [16:0] msum = {1'b0, acc} + (wq[0] ? {1'b0, wd} : 17'd0);
  wire [16:0] dsh  = {acc, wq[31]};
  wire [17:0] dtr  = {1'b0, dsh} - {2'b00, wd};
  wire        dge  = ~dtr[17];

  logic [15:0] acc_n;
  logic [31:0] wq_n;
  always_comb begin
    if (is_div) begin
      acc_n = dge ? dtr[15:0] : dsh[15:0];
      wq_n  = {wq[30:0], dge};
    end else begin
      acc_n = msum[16:1];
      wq_n  = {wq[31:16], msum[0], wq[15:1]};
    end
  end

  wire last = busy && (cnt == (is_div ? CW'(DIV_N - 1) : CW'(MUL_N - 1)));
  wire step = busy && !go && !clr;
  wire fin  = step && last;
  wire [31:0] prod  = {acc_n, wq_n[15:0]};
  wire [31:0] res_n = is_div ? (dz ? 32'd0 : (neg_q ? -wq_n : wq_n))
                             : (neg_q ? -prod : prod);
  wire [15:0] rem_n = dz ? dlow : (neg_r ? -acc_n : acc_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd <= '0; mpy <= '0; dvs <= '0; res <= '0; rem <= '0; ctl <= '0;
      busy <= 1'b0; is_div <= 1'b0; done <= 1'b0; neg_q <= 1'b0; neg_r <= 1'b0;
      dz <= 1'b0; cnt <= '0; acc <= '0; wq <= '0; wd <= '0; dlow <= '0;
    end else begin
      if (clr) begin
        dvd <= '0; mpy <= '0; dvs <= '0; res <= '0; rem <= '0;
        ctl <= wdata;
        busy <= 1'b0;
      end else if (wr_en) begin
        case (addr)
          4'd0: dvd[7:0]   <= wdata;
          4'd1: dvd[15:8]  <= wdata;
          4'd2: dvd[23:16] <= wdata;
          4'd3: dvd[31:24] <= wdata;
          4'd4: mpy[7:0]   <= wdata;
          4'd5: mpy[15:8]  <= wdata;
          4'd6: dvs[7:0]   <= wdata;
          4'd7: dvs[15:8]  <= wdata;
          default: ;
        endcase
      end

      if (go) begin
        busy   <= 1'b1;
        cnt    <= '0;
        is_div <= go_div;
        acc    <= '0;
        if (go_div) begin
          wq    <= mag_d;
          wd    <= mag_v;
          neg_q <= sgn && (dvd[31] ^ dvs_n[15]);
          neg_r <= sgn && dvd[31];
          dz    <= dvs_n == 16'd0;
          dlow  <= dvd[15:0];
        end else begin
          wq    <= {16'd0, mag_m};
          wd    <= mag_a;
          neg_q <= sgn && (dvd[15] ^ mpy_n[15]);
          neg_r <= 1'b0;
          dz    <= 1'b0;
          dlow  <= '0;
        end
      end else if (step) begin
        acc <= acc_n;
        wq  <= wq_n;
        cnt <= cnt + 1'b1;
        if (last) begin
          busy <= 1'b0;
          res  <= res_n;
          if (is_div) rem <= rem_n;
        end
      end

      if (clr || go)                     done <= 1'b0;
      else if (fin)                      done <= 1'b1;
      else if (rd_en && addr == A_STA)   done <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      4'd0:  rdata = dvd[7:0];
      4'd1:  rdata = dvd[15:8];
      4'd2:  rdata = dvd[23:16];
      4'd3:  rdata = dvd[31:24];
      4'd4:  rdata = mpy[7:0];
      4'd5:  rdata = mpy[15:8];
      4'd6:  rdata = dvs[7:0];
      4'd7:  rdata = dvs[15:8];
      4'd8:  rdata = res[7:0];
      4'd9:  rdata = res[15:8];
      4'd10: rdata = res[23:16];
      4'd11: rdata = res[31:24];
      4'd12: rdata = rem[7:0];
      4'd13: rdata = rem[15:8];
      4'd14: rdata = ctl;
      default: rdata = {done, 7'd0};
    endcase
  end

  AST_BUSY_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !done); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (is_div || cnt <= CW'(MUL_N - 1))); // R10
  AST_GO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) go |=> (busy && cnt == '0)); // R10
  AST_FIN_FLAG: assert property (@(posedge clk) disable iff (!rst_n) fin |=> (done && !busy)); // R8
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last) |=> ($stable(res) && $stable(rem))); // R3
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (dvd == '0 && mpy == '0 && dvs == '0 && res == '0 && rem == '0 && !busy && !done)); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_STA && !busy && !wr_en) |=> !done); // R8
endmodule

// File: tb/muldiv_regs_bench.sv
module muldiv_regs_bench;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  wire  [7:0] rdata;
  int total = 0, bad = 0;

  muldiv_regs u_muldiv_regs (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                             .addr(addr), .wdata(wdata), .rdata(rdata));

  always #(CLK_NS/2) clk = ~clk;

  bit [7:0]  mb [16];
  bit        m_done;
  int        m_cnt;
  bit [31:0] p_res;
  bit [15:0] p_rem;
  bit        p_div;

  function automatic bit [7:0] m_read(input bit [3:0] a);
    return (a == 4'd15) ? {m_done, 7'd0} : mb[a];
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic void m_start(input bit dv);
    bit s = mb[14][0];
    longint x, y, q, r;
    if (dv) begin
      x = {mb[3], mb[2], mb[1], mb[0]};
      if (s && x >= 64'sh80000000) x -= 64'sh100000000;
      y = {mb[7], mb[6]};
      if (s && y >= 32768) y -= 65536;
      if (y == 0) begin q = 0; r = {mb[1], mb[0]}; end
      else begin q = x / y; r = x % y; end
      p_res = q[31:0];
      p_rem = r[15:0];
      m_cnt = 32;
    end else begin
      x = {mb[1], mb[0]};
      if (s && x >= 32768) x -= 65536;
      y = {mb[5], mb[4]};
      if (s && y >= 32768) y -= 65536;
      q = x * y;
      p_res = q[31:0];
      m_cnt = 16;
    end
    p_div  = dv;
    m_done = 1'b0;
  endfunction

  task automatic cyc(input bit we, input bit re, input bit [3:0] a, input bit [7:0] d, input string tag);
    bit started = 1'b0, fin = 1'b0;
    wr_en = we; rd_en = re; addr = a; wdata = d;
    #1;
    if (re) check($sformatf("%s rd[%0d]", tag, a), rdata, m_read(a));
    @(posedge clk);
    if (we && a == 4'd14) begin
      for (int i = 0; i < 14; i++) mb[i] = 8'd0;
      mb[14] = d; m_cnt = 0; m_done = 1'b0;
    end else if (we && a < 4'd8) begin
      mb[a] = d;
      if (a == 4'd5) begin m_start(1'b0); started = 1'b1; end
      if (a == 4'd7) begin m_start(1'b1); started = 1'b1; end
    end
    if (!started && !(we && a == 4'd14) && m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) begin
        fin = 1'b1; m_done = 1'b1;
        for (int i = 0; i < 4; i++) mb[8+i] = p_res[8*i +: 8];
        if (p_div) begin mb[12] = p_rem[7:0]; mb[13] = p_rem[15:8]; end
      end
    end
    if (re && a == 4'd15 && !fin && !started) m_done = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input bit [3:0] a, input bit [7:0] d, input string tag);
    cyc(1'b1, 1'b0, a, d, tag);
  endtask
  task automatic rd(input bit [3:0] a, input string tag);
    cyc(1'b0, 1'b1, a, 8'd0, tag);
  endtask

  task automatic poll_and_read(input string tag);
    for (int k = 0; k < 40; k++) begin
      bit was = m_done;
      rd(4'd15, {tag, " R8 status"});
      if (was) break;
    end
    for (int i = 8; i < 14; i++) rd(4'(i), tag);
    rd(4'd15, {tag, " R8 after clear"});
  endtask

  task automatic run_op(input bit s, input bit dv, input bit [31:0] a, input bit [15:0] b, input string tag);
    wr(4'd14, {7'd0, s}, tag);
    if (dv) begin
      for (int i = 0; i < 4; i++) wr(4'(i), a[8*i +: 8], tag);
      wr(4'd6, b[7:0], tag);
      wr(4'd7, b[15:8], tag);
    end else begin
      wr(4'd0, a[7:0], tag);
      wr(4'd1, a[15:8], tag);
      wr(4'd4, b[7:0], tag);
      wr(4'd5, b[15:8], tag);
    end
    poll_and_read(tag);
  endtask

  function automatic bit [31:0] pick32();
    case ($urandom_range(0, 5))
      0: return 32'h80000000;
      1: return 32'hFFFFFFFF;
      2: return 32'h00000000;
      default: return $urandom;
    endcase
  endfunction
  function automatic bit [15:0] pick16();
    case ($urandom_range(0, 7))
      0: return 16'h8000;
      1: return 16'hFFFF;
      2: return 16'h0000;
      3: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mb[i] = 8'd0;
    m_done = 1'b0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) rd(4'(i), "R1 reset");

    for (int i = 0; i < 8; i++) if (i != 5 && i != 7) wr(4'(i), 8'(8'h11 * (i + 1)), "R2");
    for (int i = 0; i < 8; i++) rd(4'(i), "R2 readback");
    wr(4'd9, 8'hA5, "R2"); rd(4'd9, "R2 ignored write");
    wr(4'd12, 8'h5A, "R2"); rd(4'd12, "R2 ignored write");
    wr(4'd15, 8'hFF, "R2"); rd(4'd15, "R2 ignored write");

    run_op(0, 0, 32'h0000FFFF, 16'hFFFF, "R3 mul max");
    run_op(0, 0, 32'd1234, 16'd5678, "R3 mul");
    run_op(0, 0, 32'd0, 16'h7777, "R3 mul zero");
    run_op(1, 0, 32'h8000, 16'h8000, "R4 smul minmin");
    run_op(1, 0, 32'hFFFF, 16'd5, "R4 smul neg");
    run_op(1, 0, 32'h7FFF, 16'h8000, "R4 smul mixed");
    run_op(0, 1, 32'hFFFFFFFF, 16'hFFFF, "R5 div max");
    run_op(0, 1, 32'd100, 16'd7, "R5 div");
    run_op(0, 1, 32'd5, 16'd9, "R5 div small");
    run_op(1, 1, -32'sd7, 16'd2, "R6 sdiv neg dividend");
    run_op(1, 1, 32'd7, -16'sd2, "R6 sdiv neg divisor");
    run_op(1, 1, 32'h80000000, 16'hFFFF, "R6 sdiv overflow");
    run_op(1, 1, 32'h80000000, 16'h8000, "R6 sdiv minmin");
    run_op(0, 1, 32'h12345678, 16'd0, "R7 div zero");
    run_op(1, 1, 32'h8000ABCD, 16'd0, "R7 sdiv zero");

    wr(4'd14, 8'd0, "R10");
    wr(4'd0, 8'd3, "R10"); wr(4'd1, 8'd0, "R10");
    wr(4'd4, 8'd10, "R10"); wr(4'd5, 8'd0, "R10");
    for (int k = 0; k < 5; k++) rd(4'd15, "R10 busy status");
    wr(4'd5, 8'd2, "R10 restart");
    poll_and_read("R10 restarted mul");

    wr(4'd0, 8'hFF, "R9"); wr(4'd3, 8'h40, "R9");
    wr(4'd6, 8'd3, "R9"); wr(4'd7, 8'd0, "R9");
    for (int k = 0; k < 3; k++) rd(4'd15, "R9 busy status");
    wr(4'd14, 8'h81, "R9 control");
    for (int i = 0; i < 15; i++) rd(4'(i), "R9 cleared");
    for (int k = 0; k < 40; k++) rd(4'd15, "R9 cancelled status");
    rd(4'd8, "R9 no late result");

    for (int n = 0; n < 300; n++) begin
      bit s = 1'($urandom);
      bit dv = 1'($urandom);
      run_op(s, dv, pick32(), pick16(), dv ? (s ? "R6 rand" : "R5 rand") : (s ? "R4 rand" : "R3 rand"));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule